// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides its input clock by a 16-bit ratio N and emits one single-cycle pulse per N input cycles. The count is built from three cooperating counters: a prescaler that divides by 5 or by 4, a 2-bit swallow counter, and a 14-bit main counter. The two low bits of N load the swallow counter (S). The upper fourteen bits set the main count (M). The prescaler runs in its divide-by-5 mode while swallow counts remain and in its divide-by-4 mode afterwards, so one output period lasts 5·S + 4·(M−S) = 4·M + S input cycles.

A new ratio arrives on a plain strobe-and-data control pair. The value waits in a pending register and moves into the active register only at the end of the running output period, so no period is ever cut short. The control inputs have no back-pressure: a strobe is taken in every cycle it is high, and the last value strobed before a period boundary wins. A main count below 7 is raised to 7 so that the swallow counter always runs out before the main counter wraps.

Top module: `psd_divider`

## Requirements
- R1: While reset is low, `div_pulse` stays 0. After reset the active ratio is the parameter RESET_RATIO (default 100). The first pulse comes in the input cycle with index RESET_RATIO−1, counting the first cycle after reset release as index 0.
- R2: The prescaler divides by 5 while the swallow count is nonzero and by 4 once it reaches zero. For each swallow value 0, 1, 2 and 3, the period is therefore 4·M + S.
- R3: `div_pulse` is high for exactly one input cycle per output period. The distance between consecutive pulses equals the effective ratio.
- R4: The ratio splits as M = cfg_ratio[15:2] and S = cfg_ratio[1:0]. For example, 12156 gives M = 3039 and S = 0, which is a period of 12156 cycles.
- R5: An M below 7 is clamped to 7 and S is kept, so the effective ratio is 28 + S. For example, ratio 5 gives a period of 29.
- R6: A ratio loaded in a cycle without a pulse does not change the period in progress. It is used from the following period onward.
- R7: A ratio loaded in the same cycle as `div_pulse` governs the very next period.
- R8: When several loads occur within one period, only the last one takes effect at the boundary.
- R9: The largest ratio, 65535 (M = 16383, S = 3), gives a period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe: capture `cfg_ratio` as the pending ratio |
| cfg_ratio | input | 16 | Requested division ratio N |
| div_pulse | output | 1 | One-cycle pulse at the last input cycle of each period |

## Verification
Two events can fall in the same cycle: the period boundary, marked by `div_pulse`, and a ratio load on `cfg_load`. The bench provokes this by arming a load that it drives only in a cycle where it has just seen the pulse. It repeats this on purpose for several ratios and also by chance during the random phase. The bench then checks that the next pulse interval equals the freshly loaded ratio and not the older pending one, while loads made away from the boundary must leave the running interval unchanged.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int RATIO_W  = 16;
  localparam int SWAL_W   = 2;
  localparam int MAIN_W   = RATIO_W - SWAL_W;
  localparam int PRE_BASE = 4;
  localparam int PCNT_W   = $clog2(PRE_BASE + 1);
  localparam int M_FLOOR  = 7;

  typedef struct packed {
    logic [MAIN_W-1:0] m;
    logic [SWAL_W-1:0] s;
  } psd_ratio_t;

  function automatic psd_ratio_t split_ratio(input logic [RATIO_W-1:0] n);
    psd_ratio_t r;
    r.s = n[SWAL_W-1:0];
    r.m = n[RATIO_W-1:SWAL_W];
    if (r.m < MAIN_W'(M_FLOOR)) r.m = MAIN_W'(M_FLOOR);
    return r;
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic extra_cycle,
  output logic tick
);
  localparam logic [PCNT_W-1:0] LAST_BASE  = PCNT_W'(PRE_BASE - 1);
  localparam logic [PCNT_W-1:0] LAST_EXTRA = PCNT_W'(PRE_BASE);

  logic [PCNT_W-1:0] pcnt;

  assign tick = (pcnt == (extra_cycle ? LAST_EXTRA : LAST_BASE));

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  assert_pcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= LAST_EXTRA);

  // R2: modulus drops from 5 to 4 only on a prescaler boundary
  assert_mod_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(extra_cycle) |-> pcnt == '0);
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
#(
  parameter logic [SWAL_W-1:0] RST_S = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload,
  input  logic [SWAL_W-1:0] load_val,
  output logic              pending
);
  logic [SWAL_W-1:0] scnt;

  assign pending = (scnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               scnt <= RST_S;
    else if (reload)          scnt <= load_val;
    else if (tick && pending) scnt <= scnt - 1'b1;
  end

  // R2: swallow count only moves on a prescaler tick or a reload
  assert_swallow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(scnt));
endmodule

// File: rtl/psd_main_counter.sv
module psd_main_counter
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MAIN_W-1:0] limit,
  output logic              wrap
);
  logic [MAIN_W-1:0] mcnt;

  assign wrap = tick && (mcnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)    mcnt <= '0;
    else if (wrap) mcnt <= '0;
    else if (tick) mcnt <= mcnt + 1'b1;
  end

  assert_main_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt < limit);
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter logic [15:0] RESET_RATIO = 16'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [15:0] cfg_ratio,
  output logic        div_pulse
);
  localparam psd_ratio_t RST_R = split_ratio(RESET_RATIO);

  psd_ratio_t pend_q, act_q, next_r;
  logic       tick, swal_pending, boundary;

  // a load in the boundary cycle bypasses the pending register
  assign next_r    = cfg_load ? split_ratio(cfg_ratio) : pend_q;
  assign div_pulse = boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= RST_R;
      act_q  <= RST_R;
    end else begin
      if (cfg_load) pend_q <= split_ratio(cfg_ratio);
      if (boundary) act_q  <= next_r;
    end
  end

  psd_prescaler u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .extra_cycle (swal_pending),
    .tick        (tick)
  );

  psd_swallow #(.RST_S(RST_R.s)) u_swal (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reload   (boundary),
    .load_val (next_r.s),
    .pending  (swal_pending)
  );

  psd_main_counter u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .limit (act_q.m),
    .wrap  (boundary)
  );

  assert_m_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.m >= MAIN_W'(M_FLOOR));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |=> $stable(act_q));

  // R2: all swallow counts are used up before the main counter wraps
  assert_swallow_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> !swal_pending);
endmodule

// File: tb/psd_divider_bench.sv
module psd_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_ratio = '0;
  logic        div_pulse;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  int last   = -1;
  int pulses = 0;
  bit last_ld_eff = 0;
  logic [15:0] pend_exp = 16'd100;
  logic [15:0] act_exp  = 16'd100;
  string tag = "R1";

  always #10 clk = ~clk;

  psd_divider u_psd_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_ratio (cfg_ratio),
    .div_pulse (div_pulse)
  );

  function automatic int eff(input logic [15:0] n);
    int m = int'(n >> 2);
    if (m < 7) m = 7;
    return 4 * m + int'(n & 16'd3);
  endfunction

  task automatic check(input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, idx);
    end
  endtask

  task automatic step(input bit ld, input logic [15:0] v, input bit only_on_pulse);
    bit p;
    bit ld_eff;
    @(negedge clk);
    idx++;
    p = div_pulse;
    if (p) begin
      check(idx - last == eff(act_exp), idx - last, eff(act_exp));
      last = idx;
      pulses++;
    end
    ld_eff = ld && (!only_on_pulse || p);
    if (p) act_exp = ld_eff ? v : pend_exp;
    if (ld_eff) pend_exp = v;
    last_ld_eff = ld_eff;
    cfg_load  = ld_eff;
    cfg_ratio = v;
  endtask

  task automatic run_pulses(input int n);
    int start = pulses;
    int guard = 0;
    while (pulses < start + n) begin
      step(0, 16'd0, 0);
      guard++;
      if (guard > 70000) begin
        check(0, guard, 0);
        break;
      end
    end
  endtask

  task automatic load_at_pulse(input logic [15:0] v);
    int guard = 0;
    do begin
      step(1, v, 1);
      guard++;
    end while (!last_ld_eff && guard < 70000);
    if (!last_ld_eff) check(0, guard, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tag = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(div_pulse == 1'b0, int'(div_pulse), 0);
    end
    rst_n = 1'b1;
    idx = 0;
    run_pulses(3);

    for (int s = 0; s < 4; s++) begin
      tag = (s == 0) ? "R2" : "R4";
      step(0, 16'd0, 0);
      step(1, 16'(40 + s), 0);
      run_pulses(2);
    end

    tag = "R5";
    step(1, 16'd5, 0);
    run_pulses(2);
    step(1, 16'd0, 0);
    run_pulses(2);

    tag = "R6";
    step(1, 16'd90, 0);
    run_pulses(1);
    repeat (10) step(0, 16'd0, 0);
    step(1, 16'd33, 0);
    run_pulses(2);

    tag = "R7";
    step(1, 16'd50, 0);
    load_at_pulse(16'd37);
    run_pulses(2);
    load_at_pulse(16'd30);
    run_pulses(1);

    tag = "R8";
    step(1, 16'd60, 0);
    step(1, 16'd64, 0);
    step(1, 16'd71, 0);
    run_pulses(3);

    tag = "R4";
    step(1, 16'd12156, 0);
    run_pulses(1);
    tag = "R9";
    load_at_pulse(16'd65535);
    load_at_pulse(16'd28);
    run_pulses(1);

    tag = "R6";
    for (int k = 0; k < 25000; k++) begin
      bit ld = ($urandom_range(0, 39) == 0);
      step(ld, 16'($urandom_range(0, 600)), bit'($urandom_range(0, 1)));
    end
    run_pulses(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule